// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Binary Counter

This block is a binary up-counter built from identical fixed-width slices that are chained into one wider, fully synchronous counter. Each slice holds a small register and follows a fixed priority of operations on every rising clock edge. A synchronous clear comes first, then a parallel load, then counting, and otherwise the slice holds its value. Two active-high count enables must both be high for a slice to count. Only the second enable, the cascade enable, reaches the slice's terminal-count carry output. This lets the carry of one slice drive the cascade enable of the next.

The wrapper shares clock, clear, load and the first enable across all slices. Slice 0 takes the external cascade enable. Each later slice takes the carry of the slice below it. Seen from outside, the chain behaves like a single register of the combined width. It has a parallel load word and a carry that flags the all-ones state. There is no asynchronous reset: the state is defined after the first clear edge.

Top module: `sync_cnt_chain`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, `cnt_q` becomes all zeros after that edge, whatever the values of `ld_n`, `en_p`, `en_t` and `din`.
- R2: When `clr_n` is 1 and `ld_n` is 0 at a rising edge, `cnt_q` takes the value of `din` after that edge, for every combination of `en_p` and `en_t`.
- R3: When `clr_n` and `ld_n` are both 1 and `en_p` and `en_t` are both 1 at a rising edge, `cnt_q` increases by one modulo 2^TOTAL_W, so all ones wraps to zero.
- R4: When `clr_n` and `ld_n` are both 1 and either `en_p` or `en_t` is 0 at a rising edge, `cnt_q` keeps its value.
- R5: `carry_o` is 1 exactly when `en_t` is 1 and every bit of `cnt_q` is 1. It is combinational, valid in the same cycle without waiting for an edge, and does not depend on `en_p`.
- R6: Bit i of `din` loads into bit i of `cnt_q`. Bit 0 is the least significant bit of both.
- R7: The SLICE_W-bit slices, NUM_SLICES of them with TOTAL_W = SLICE_W*NUM_SLICES, count together exactly like one TOTAL_W-bit counter. Each slice above slice 0 counts only when every lower slice is all ones and `en_t` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low |
| din | input | TOTAL_W | Parallel load word, bit 0 least significant |
| en_p | input | 1 | Count enable that does not reach the carry |
| en_t | input | 1 | Cascade count enable, also gates the carry |
| cnt_q | output | TOTAL_W | Counter state |
| carry_o | output | 1 | Terminal-count carry (all ones and `en_t`) |

## Verification
Clear, load, count and hold each act at the first rising edge after the controls are applied, so `cnt_q` is due one edge later. The carry is combinational and is due in the same cycle that `en_t` or the state changes. The bench drives its inputs 1 ns after a rising edge. It samples the carry 1 ns after driving, still before the next edge. It samples `cnt_q` 1 ns after that next edge and compares it with an arithmetic model of a TOTAL_W-bit counter that the bench advances once per edge.

// File: rtl/sync_cnt_pkg.sv
package sync_cnt_pkg;

    // Operating mode of one slice, in falling priority order.
    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_COUNT = 2'd2,
        MODE_HOLD  = 2'd3
    } cnt_mode_e;

endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
    import sync_cnt_pkg::*;
(
    input  logic      clr_n,
    input  logic      ld_n,
    input  logic      en_p,
    input  logic      en_t,
    output cnt_mode_e mode
);

    // Clear beats load, load beats count, count beats hold.
    always_comb begin
        if (!clr_n) begin
            mode = MODE_CLEAR;
        end else if (!ld_n) begin
            mode = MODE_LOAD;
        end else if (en_p && en_t) begin
            mode = MODE_COUNT;
        end else begin
            mode = MODE_HOLD;
        end
    end

endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
    import sync_cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         ld_n,
    input  logic         en_p,
    input  logic         en_t,
    input  logic [W-1:0] din,
    output logic [W-1:0] cnt_q,
    output logic         carry_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } slice_st_t;

    cnt_mode_e mode;
    slice_st_t st_d;
    slice_st_t st_q;
    logic      armed_q = 1'b0;

    cnt_mode_dec u_dec (
        .clr_n (clr_n),
        .ld_n  (ld_n),
        .en_p  (en_p),
        .en_t  (en_t),
        .mode  (mode)
    );

    always_comb begin
        st_d = st_q;
        unique case (mode)
            MODE_CLEAR: st_d.cnt = '0;
            MODE_LOAD:  st_d.cnt = din;
            MODE_COUNT: st_d.cnt = st_q.cnt + W'(1);
            default:    st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (!clr_n) begin
            armed_q <= 1'b1;
        end
    end

    assign cnt_q   = st_q.cnt;
    // Terminal count, gated only by the cascade enable.
    assign carry_o = en_t & (&st_q.cnt);

    // R1: clear wins over everything.
    a_r1_clear_zero: assert property (@(posedge clk) disable iff (!armed_q)
        !clr_n |=> (cnt_q == '0));

    // R2: load captures the data word.
    a_r2_load_capture: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && !ld_n) |=> (cnt_q == $past(din)));

    // R3: count steps by one, modulo the width.
    a_r3_count_step: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && ld_n && en_p && en_t) |=> (cnt_q == W'($past(cnt_q) + W'(1))));

    // R4: either enable low holds the value.
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && ld_n && !(en_p && en_t)) |=> $stable(cnt_q));

endmodule

// File: rtl/sync_cnt_chain.sv
module sync_cnt_chain
    import sync_cnt_pkg::*;
#(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 2,
    localparam int TOTAL_W   = SLICE_W * NUM_SLICES
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               ld_n,
    input  logic [TOTAL_W-1:0] din,
    input  logic               en_p,
    input  logic               en_t,
    output logic [TOTAL_W-1:0] cnt_q,
    output logic               carry_o
);

    // t_chain[k] is the cascade enable of slice k; t_chain[NUM_SLICES] is the carry out.
    logic [NUM_SLICES:0] t_chain;
    logic                armed_q = 1'b0;

    assign t_chain[0] = en_t;

    for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
        cnt_slice #(
            .W (SLICE_W)
        ) u_slice (
            .clk     (clk),
            .clr_n   (clr_n),
            .ld_n    (ld_n),
            .en_p    (en_p),
            .en_t    (t_chain[g]),
            .din     (din[g*SLICE_W +: SLICE_W]),
            .cnt_q   (cnt_q[g*SLICE_W +: SLICE_W]),
            .carry_o (t_chain[g+1])
        );
    end

    assign carry_o = t_chain[NUM_SLICES];

    always_ff @(posedge clk) begin
        if (!clr_n) begin
            armed_q <= 1'b1;
        end
    end

    // R7: the chain counts as one wide register.
    a_r7_chain_step: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && ld_n && en_p && en_t) |=> (cnt_q == TOTAL_W'($past(cnt_q) + TOTAL_W'(1))));

    // R5: carry only at full-width all ones with en_t high.
    a_r5_carry_full: assert property (@(posedge clk) disable iff (!armed_q)
        carry_o |-> (en_t && (cnt_q == {TOTAL_W{1'b1}})));

    // R5: full-width all ones with en_t high gives carry in the same cycle.
    a_r5_carry_seen: assert property (@(posedge clk) disable iff (!armed_q)
        (en_t && (cnt_q == {TOTAL_W{1'b1}})) |-> carry_o);

endmodule

// File: tb/test_sync_cnt_chain.sv
module test_sync_cnt_chain;

    localparam int SW = 4;
    localparam int NS = 2;
    localparam int TW = SW * NS;
    localparam logic [TW-1:0] ONES = {TW{1'b1}};

    logic          clk = 1'b0;
    logic          clr_n = 1'b1;
    logic          ld_n = 1'b1;
    logic [TW-1:0] din = '0;
    logic          en_p = 1'b0;
    logic          en_t = 1'b0;
    logic [TW-1:0] cnt_q;
    logic          carry_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [TW-1:0] model = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sync_cnt_chain #(.SLICE_W(SW), .NUM_SLICES(NS)) i_sync_cnt_chain (
        .clk     (clk),
        .clr_n   (clr_n),
        .ld_n    (ld_n),
        .din     (din),
        .en_p    (en_p),
        .en_t    (en_t),
        .cnt_q   (cnt_q),
        .carry_o (carry_o)
    );

    task automatic chk(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one set of controls, check carry before the edge, then the state after it.
    task automatic apply(input logic c, input logic l, input logic p, input logic t, input logic [TW-1:0] d);
        string tag;
        clr_n = c; ld_n = l; en_p = p; en_t = t; din = d;
        #1;
        chk("R5 R7 carry", TW'(carry_o), TW'(t && (model == ONES)));
        @(posedge clk);
        #1;
        if (!c) begin
            model = '0; tag = "R1 clear";
        end else if (!l) begin
            model = d; tag = "R2 R6 load";
        end else if (p && t) begin
            model = model + 1'b1; tag = "R3 R7 count";
        end else begin
            tag = "R4 hold";
        end
        chk(tag, cnt_q, model);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(posedge clk);
        #1;
        // R1: clear under every combination of the other controls.
        for (int k = 0; k < 8; k++) begin
            apply(1'b0, k[0], k[1], k[2], 8'hA5);
            chk("R1 reset state", cnt_q, '0);
        end
        // R2, R6: load every value under rotating enables.
        for (int v = 0; v < (1 << TW); v++) begin
            apply(1'b1, 1'b0, v[0], v[3], TW'(v));
        end
        // R3, R7: full count sweep including wrap and slice boundaries.
        apply(1'b1, 1'b0, 1'b0, 1'b0, '0);
        for (int i = 0; i < (1 << TW) + 20; i++) begin
            apply(1'b1, 1'b1, 1'b1, 1'b1, 8'h3C);
        end
        // R4: hold with only P low, then only T low.
        apply(1'b1, 1'b0, 1'b1, 1'b1, 8'h37);
        for (int i = 0; i < 3; i++) apply(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        for (int i = 0; i < 3; i++) apply(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        // R7: lower slice full but T low keeps the upper slice.
        apply(1'b1, 1'b0, 1'b0, 1'b0, 8'h0F);
        apply(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        apply(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        chk("R7 boundary", cnt_q, 8'h10);
        // R5: carry at all ones while P is low, and gone when T drops.
        apply(1'b1, 1'b0, 1'b0, 1'b0, ONES);
        apply(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        apply(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        apply(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        chk("R3 wrap", cnt_q, 8'h00);
        // R2: load while counting.
        apply(1'b1, 1'b0, 1'b1, 1'b1, 8'h10);
        apply(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        apply(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        apply(1'b1, 1'b0, 1'b1, 1'b1, 8'hC3);
        chk("R2 load over count", cnt_q, 8'hC3);
        // R1: clear together with load.
        apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h5A);
        chk("R1 clear over load", cnt_q, 8'h00);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule